// File: doc/BRIEF.md
# Zero-Substitution Line Codec (three-zero / four-zero)

This block sits between a framer's bit stream and the dual-rail logic signals of a bipolar line driver and receiver. In the transmit direction it takes one NRZ bit per beat and produces a positive-pulse flag and a negative-pulse flag per beat. Ordinary marks alternate in polarity. Runs of zeros are replaced by patterns that contain a deliberate polarity violation. In the receive direction it takes the two recovered pulse flags and rebuilds the NRZ bits. It finds each violation and erases the whole substitution window that ends with it.

A rate select picks the substitution window: three zeros for the 44.7 and 51.8 Mbit/s rates, and four zeros for the 34.4 Mbit/s rate. An active-low codec enable can turn the coding off, so that dual-rail flags pass through in both directions. An active-high signal-present input blanks the receive outputs while it is low. Both mode pins are captured only while a direction's synchronous reset is high. Each direction has its own clock and reset.

Both directions are valid/ready streams built as lockstep pipelines W beats deep. W is 3 in three-zero mode and 4 in four-zero mode. An output beat is offered only in a cycle where an input beat is also offered, and only once W beats have been accepted since reset. An input beat is accepted when the output side is ready or when the pipeline is not yet full. When the sink holds ready low on a full pipeline, the source is stalled and the offered output stays unchanged. The W beats still in the pipeline leave only as further beats are pushed in.

Top module: `zsub_codec`

## Requirements
- R1: The transmit flags are never both high. In bypass mode, an input pair with both flags high is sent as a zero symbol.
- R2: In each direction, out_valid = (W beats accepted since reset) AND in_valid, and in_ready = out_ready OR (fewer than W accepted). A beat is accepted when in_valid AND in_ready. The k-th output beat carries the result for the k-th input beat. An offered output that is not taken stays stable in the next cycle.
- R3: Three-zero mode (hdb3_sel=0 at reset, codec on). A one becomes a pulse of the opposite polarity to the last pulse sent. Each aligned run of three zeros becomes 0,0,V if an odd number of pulses has been sent since the last substitution, and B,0,V otherwise. B takes the opposite polarity to the last pulse. V takes the same polarity as the pulse before it. After reset, the last pulse counts as negative and the count as even.
- R4: Four-zero mode (hdb3_sel=1 at reset) applies the R3 rules to runs of four zeros, giving 0,0,0,V or B,0,0,V.
- R5: With the codec on, the transmit line carries at most W-1 consecutive zero symbols.
- R6: With the codec on, the receive side outputs a one for each pulse whose polarity differs from the previous pulse. A pulse of the same polarity is a violation: it decodes as zero and clears the W-1 bits before it. At reset the previous pulse counts as negative.
- R7: With the codec on, rx_out_neg is always low and the NRZ bit appears on rx_out_pos.
- R8: With the codec on, tx_in_neg has no effect on the line. With the codec off, a transmit pair {pos,neg} appears on the line W beats later.
- R9: With the codec off, a receive pair is output unchanged W beats later.
- R10: While sig_present is low, rx_out_pos and rx_out_neg are low.
- R11: Changes of codec_en_n or hdb3_sel while reset is low have no effect on either direction.
- R12: Right after reset, out_valid is low and in_ready is high in both directions, and the transmit line flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock |
| tx_rst | input | 1 | Transmit synchronous reset, active high; captures mode pins |
| rx_clk | input | 1 | Receive clock |
| rx_rst | input | 1 | Receive synchronous reset, active high; captures mode pins |
| codec_en_n | input | 1 | 0: substitution coding on; 1: dual-rail bypass |
| hdb3_sel | input | 1 | 0: three-zero window; 1: four-zero window |
| sig_present | input | 1 | 0 blanks the receive outputs |
| tx_in_valid | input | 1 | Transmit input beat offered |
| tx_in_ready | output | 1 | Transmit input beat accepted |
| tx_in_pos | input | 1 | NRZ bit (codec on) or positive flag (bypass) |
| tx_in_neg | input | 1 | Negative flag (bypass only) |
| tx_out_valid | output | 1 | Line symbol offered |
| tx_out_ready | input | 1 | Line side takes the symbol |
| tx_line_pos | output | 1 | Positive pulse flag |
| tx_line_neg | output | 1 | Negative pulse flag |
| rx_in_valid | input | 1 | Received symbol offered |
| rx_in_ready | output | 1 | Received symbol accepted |
| rx_line_pos | input | 1 | Recovered positive pulse flag |
| rx_line_neg | input | 1 | Recovered negative pulse flag |
| rx_out_valid | output | 1 | Decoded beat offered |
| rx_out_ready | input | 1 | Framer takes the decoded beat |
| rx_out_pos | output | 1 | NRZ bit (codec on) or positive flag (bypass) |
| rx_out_neg | output | 1 | Low (codec on) or negative flag (bypass) |

## Verification
The assertions check the following on every cycle: the two transmit flags are exclusive, the zero-run limit on the coded line holds, the receive negative output stays low in NRZ mode, blanking during signal loss works, valid is offered only with an input beat, a stalled output stays stable, and both directions are idle right after reset. Only the bench's scenarios can show that each symbol is correct. That covers the B-versus-V choice, the polarity of each substitution pulse, a round trip through the decoder back to the original bits, exact pass-through in bypass, and that mode pins toggled outside reset are ignored. For those, the bench compares against a behavioural model under random stalls on both sides.

// File: rtl/zsub_pkg.sv
package zsub_pkg;
  localparam int unsigned B3_WIN  = 3;
  localparam int unsigned HDB_WIN = 4;
  localparam int unsigned MAX_WIN = (B3_WIN > HDB_WIN) ? B3_WIN : HDB_WIN;
  localparam int unsigned IDX_W   = $clog2(MAX_WIN);
  localparam int unsigned FILL_W  = $clog2(MAX_WIN + 1);

  typedef struct packed {
    logic p;
    logic n;
  } rail_t;

  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} pol_t;

  localparam rail_t RAIL_ZERO = '{p: 1'b0, n: 1'b0};

  function automatic pol_t pol_flip(pol_t x);
    return (x == POL_POS) ? POL_NEG : POL_POS;
  endfunction

  function automatic rail_t pol_pulse(pol_t x);
    rail_t r;
    r.p = (x == POL_POS);
    r.n = (x == POL_NEG);
    return r;
  endfunction
endpackage

// File: rtl/zsub_mode_reg.sv
module zsub_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic codec_en_n,
  input  logic hdb3_sel,
  output logic bypass,
  output logic hdb3
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bypass <= codec_en_n;
      hdb3   <= hdb3_sel;
    end
  end
endmodule

// File: rtl/zsub_flow.sv
module zsub_flow
  import zsub_pkg::*;
#(
  parameter int unsigned DEPTH = MAX_WIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             step
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fill;
  logic          full;

  assign full      = (fill > CW'(last_idx));
  assign in_ready  = out_ready | ~full;
  assign out_valid = full & in_valid;
  assign step      = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (step && !full) fill <= fill + 1'b1;
  end
endmodule

// File: rtl/zsub_encoder.sv
module zsub_encoder
  import zsub_pkg::*;
#(
  parameter int unsigned DEPTH = MAX_WIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             bypass,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             in_pos,
  input  logic             in_neg,
  output rail_t            out_rail
);
  rail_t [DEPTH-1:0] pipe, pipe_d;
  pol_t              last_pol, last_pol_d;
  logic              odd, odd_d;
  logic [IDX_W-1:0]  zrun, zrun_d;

  always_comb begin
    pipe_d     = pipe;
    last_pol_d = last_pol;
    odd_d      = odd;
    zrun_d     = zrun;
    for (int k = DEPTH - 1; k > 0; k--) pipe_d[k] = pipe[k-1];
    if (bypass) begin
      pipe_d[0] = (in_pos & in_neg) ? RAIL_ZERO : '{p: in_pos, n: in_neg};
    end else if (in_pos) begin
      pipe_d[0]  = pol_pulse(pol_flip(last_pol));
      last_pol_d = pol_flip(last_pol);
      odd_d      = ~odd;
      zrun_d     = '0;
    end else if (zrun == last_idx) begin
      if (odd) begin
        pipe_d[0] = pol_pulse(last_pol);
      end else begin
        pipe_d[last_idx] = pol_pulse(pol_flip(last_pol));
        pipe_d[0]        = pol_pulse(pol_flip(last_pol));
        last_pol_d       = pol_flip(last_pol);
      end
      odd_d  = 1'b0;
      zrun_d = '0;
    end else begin
      pipe_d[0] = RAIL_ZERO;
      zrun_d    = zrun + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      last_pol <= POL_NEG;
      odd      <= 1'b0;
      zrun     <= '0;
    end else if (step) begin
      pipe     <= pipe_d;
      last_pol <= last_pol_d;
      odd      <= odd_d;
      zrun     <= zrun_d;
    end
  end

  assign out_rail = pipe[last_idx];
endmodule

// File: rtl/zsub_decoder.sv
module zsub_decoder
  import zsub_pkg::*;
#(
  parameter int unsigned DEPTH = MAX_WIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             bypass,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             in_pos,
  input  logic             in_neg,
  output rail_t            out_rail
);
  rail_t [DEPTH-1:0] pipe, pipe_d;
  pol_t              last_pol, last_pol_d;
  logic              mark;
  pol_t              pol;

  assign mark = in_pos ^ in_neg;
  assign pol  = in_pos ? POL_POS : POL_NEG;

  always_comb begin
    pipe_d     = pipe;
    last_pol_d = last_pol;
    for (int k = DEPTH - 1; k > 0; k--) pipe_d[k] = pipe[k-1];
    if (bypass) begin
      pipe_d[0] = '{p: in_pos, n: in_neg};
    end else if (!mark) begin
      pipe_d[0] = RAIL_ZERO;
    end else begin
      last_pol_d = pol;
      if (pol == last_pol) begin
        pipe_d[0] = RAIL_ZERO;
        for (int k = 1; k < DEPTH; k++) begin
          if (k <= int'(last_idx)) pipe_d[k] = RAIL_ZERO;
        end
      end else begin
        pipe_d[0] = '{p: 1'b1, n: 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      last_pol <= POL_NEG;
    end else if (step) begin
      pipe     <= pipe_d;
      last_pol <= last_pol_d;
    end
  end

  assign out_rail = pipe[last_idx];
endmodule

// File: rtl/zsub_codec.sv
module zsub_codec
  import zsub_pkg::*;
(
  input  logic tx_clk,
  input  logic tx_rst,
  input  logic rx_clk,
  input  logic rx_rst,
  input  logic codec_en_n,
  input  logic hdb3_sel,
  input  logic sig_present,
  input  logic tx_in_valid,
  output logic tx_in_ready,
  input  logic tx_in_pos,
  input  logic tx_in_neg,
  output logic tx_out_valid,
  input  logic tx_out_ready,
  output logic tx_line_pos,
  output logic tx_line_neg,
  input  logic rx_in_valid,
  output logic rx_in_ready,
  input  logic rx_line_pos,
  input  logic rx_line_neg,
  output logic rx_out_valid,
  input  logic rx_out_ready,
  output logic rx_out_pos,
  output logic rx_out_neg
);
  logic             tx_byp, tx_hdb, tx_step;
  logic             rx_byp, rx_hdb, rx_step;
  logic [IDX_W-1:0] tx_last, rx_last;
  rail_t            tx_rail, rx_rail;

  zsub_mode_reg u_tx_mode (
    .clk(tx_clk), .rst(tx_rst), .codec_en_n(codec_en_n), .hdb3_sel(hdb3_sel),
    .bypass(tx_byp), .hdb3(tx_hdb)
  );
  zsub_mode_reg u_rx_mode (
    .clk(rx_clk), .rst(rx_rst), .codec_en_n(codec_en_n), .hdb3_sel(hdb3_sel),
    .bypass(rx_byp), .hdb3(rx_hdb)
  );

  assign tx_last = tx_hdb ? IDX_W'(HDB_WIN - 1) : IDX_W'(B3_WIN - 1);
  assign rx_last = rx_hdb ? IDX_W'(HDB_WIN - 1) : IDX_W'(B3_WIN - 1);

  zsub_flow #(.DEPTH(MAX_WIN)) u_tx_flow (
    .clk(tx_clk), .rst(tx_rst), .last_idx(tx_last),
    .in_valid(tx_in_valid), .out_ready(tx_out_ready),
    .in_ready(tx_in_ready), .out_valid(tx_out_valid), .step(tx_step)
  );
  zsub_flow #(.DEPTH(MAX_WIN)) u_rx_flow (
    .clk(rx_clk), .rst(rx_rst), .last_idx(rx_last),
    .in_valid(rx_in_valid), .out_ready(rx_out_ready),
    .in_ready(rx_in_ready), .out_valid(rx_out_valid), .step(rx_step)
  );

  zsub_encoder #(.DEPTH(MAX_WIN)) u_enc (
    .clk(tx_clk), .rst(tx_rst), .step(tx_step), .bypass(tx_byp),
    .last_idx(tx_last), .in_pos(tx_in_pos), .in_neg(tx_in_neg),
    .out_rail(tx_rail)
  );
  zsub_decoder #(.DEPTH(MAX_WIN)) u_dec (
    .clk(rx_clk), .rst(rx_rst), .step(rx_step), .bypass(rx_byp),
    .last_idx(rx_last), .in_pos(rx_line_pos), .in_neg(rx_line_neg),
    .out_rail(rx_rail)
  );

  assign tx_line_pos = tx_rail.p;
  assign tx_line_neg = tx_rail.n;
  assign rx_out_pos  = sig_present & rx_rail.p;
  assign rx_out_neg  = sig_present & rx_rail.n;
endmodule

// File: rtl/zsub_codec_checker.sv
module zsub_codec_checker
  import zsub_pkg::*;
(
  input logic tx_clk,
  input logic tx_rst,
  input logic rx_clk,
  input logic rx_rst,
  input logic codec_en_n,
  input logic hdb3_sel,
  input logic sig_present,
  input logic tx_in_valid,
  input logic tx_out_valid,
  input logic tx_out_ready,
  input logic tx_line_pos,
  input logic tx_line_neg,
  input logic rx_in_valid,
  input logic rx_out_valid,
  input logic rx_out_pos,
  input logic rx_out_neg
);
  logic       c_tx_byp, c_tx_hdb, c_rx_byp;
  logic [3:0] zero_run;
  logic [3:0] zero_lim;

  always_ff @(posedge tx_clk) begin
    if (tx_rst) begin
      c_tx_byp <= codec_en_n;
      c_tx_hdb <= hdb3_sel;
    end
  end

  always_ff @(posedge rx_clk) begin
    if (rx_rst) c_rx_byp <= codec_en_n;
  end

  assign zero_lim = c_tx_hdb ? 4'(HDB_WIN - 1) : 4'(B3_WIN - 1);

  always_ff @(posedge tx_clk) begin
    if (tx_rst) zero_run <= '0;
    else if (tx_out_valid && tx_out_ready && !c_tx_byp)
      zero_run <= (tx_line_pos || tx_line_neg) ? 4'd0 : zero_run + 4'd1;
  end

  p_rails_exclusive_r1: assert property (@(posedge tx_clk) disable iff (tx_rst)
    !(tx_line_pos && tx_line_neg));

  p_tx_valid_follows_input_r2: assert property (@(posedge tx_clk) disable iff (tx_rst)
    tx_out_valid |-> tx_in_valid);

  p_rx_valid_follows_input_r2: assert property (@(posedge rx_clk) disable iff (rx_rst)
    rx_out_valid |-> rx_in_valid);

  p_tx_hold_r2: assert property (@(posedge tx_clk) disable iff (tx_rst)
    (tx_out_valid && !tx_out_ready) |=> ($stable(tx_line_pos) && $stable(tx_line_neg)));

  p_zero_run_r5: assert property (@(posedge tx_clk) disable iff (tx_rst)
    (tx_out_valid && tx_out_ready && !c_tx_byp && !tx_line_pos && !tx_line_neg)
      |-> (zero_run < zero_lim));

  p_nrz_neg_low_r7: assert property (@(posedge rx_clk) disable iff (rx_rst)
    !c_rx_byp |-> !rx_out_neg);

  p_los_blank_r10: assert property (@(posedge rx_clk) disable iff (rx_rst)
    !sig_present |-> (!rx_out_pos && !rx_out_neg));

  p_tx_idle_after_reset_r12: assert property (@(posedge tx_clk) disable iff (tx_rst)
    $fell(tx_rst) |-> !tx_out_valid);

  p_rx_idle_after_reset_r12: assert property (@(posedge rx_clk) disable iff (rx_rst)
    $fell(rx_rst) |-> !rx_out_valid);
endmodule

bind zsub_codec zsub_codec_checker chk_i (
  .tx_clk(tx_clk), .tx_rst(tx_rst), .rx_clk(rx_clk), .rx_rst(rx_rst),
  .codec_en_n(codec_en_n), .hdb3_sel(hdb3_sel), .sig_present(sig_present),
  .tx_in_valid(tx_in_valid), .tx_out_valid(tx_out_valid),
  .tx_out_ready(tx_out_ready), .tx_line_pos(tx_line_pos),
  .tx_line_neg(tx_line_neg), .rx_in_valid(rx_in_valid),
  .rx_out_valid(rx_out_valid), .rx_out_pos(rx_out_pos), .rx_out_neg(rx_out_neg)
);

// File: tb/zsub_codec_tb_top.sv
`timescale 1ns/1ps
module zsub_codec_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, codec_en_n, hdb3_sel, sig_present;
  logic tx_in_valid, tx_in_ready, tx_in_pos, tx_in_neg, tx_out_valid, tx_out_ready;
  logic tx_line_pos, tx_line_neg;
  logic rx_in_valid, rx_in_ready, rx_line_pos, rx_line_neg, rx_out_valid, rx_out_ready;
  logic rx_out_pos, rx_out_neg;

  zsub_codec dut_i (
    .tx_clk(clk), .tx_rst(rst), .rx_clk(clk), .rx_rst(rst),
    .codec_en_n(codec_en_n), .hdb3_sel(hdb3_sel), .sig_present(sig_present),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_pos(tx_in_pos), .tx_in_neg(tx_in_neg),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_line_pos(tx_line_pos), .tx_line_neg(tx_line_neg),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_line_pos(rx_line_pos), .rx_line_neg(rx_line_neg),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_pos(rx_out_pos), .rx_out_neg(rx_out_neg)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h2468ace1;

  // symbol codes: 2 = positive pulse, 1 = negative pulse, 0 = zero, 3 = both flags
  int tx_in_code [512];
  int tx_exp     [512];
  int rx_in_code [512];
  int rx_exp     [512];

  function int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function int pc(int p);
    return (p > 0) ? 2 : 1;
  endfunction

  task chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  task do_reset(bit en_n, bit hdb);
    @(negedge clk);
    rst = 1'b1; codec_en_n = en_n; hdb3_sel = hdb; sig_present = 1'b1;
    tx_in_valid = 0; tx_in_pos = 0; tx_in_neg = 0; tx_out_ready = 0;
    rx_in_valid = 0; rx_line_pos = 0; rx_line_neg = 0; rx_out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R12", "tx_out_valid", int'(tx_out_valid), 0);
    chk("R12", "tx_in_ready", int'(tx_in_ready), 1);
    chk("R12", "rx_out_valid", int'(rx_out_valid), 0);
    chk("R12", "rx_in_ready", int'(rx_in_ready), 1);
    chk("R12", "tx_line", int'({tx_line_pos, tx_line_neg}), 0);
  endtask

  task automatic build_codec(int w, int n);
    int bitv [512];
    int hp [20] = '{0,0,0,0,0,0,0,0,1,0,0,0,1,1,0,0,0,0,1,0};
    int last = -1;
    int odd = 0;
    int i = 0;
    for (int k = 0; k < n; k++) begin
      bitv[k] = (k < 20) ? hp[k] : (((rnd() % 3) == 0) ? 1 : 0);
      tx_in_code[k] = bitv[k] * 2 + int'(rnd() % 2);
      rx_exp[k] = bitv[k] * 2;
    end
    while (i < n) begin
      if (bitv[i] != 0) begin
        last = -last; tx_exp[i] = pc(last); odd ^= 1; i++;
      end else begin
        bit all = (i + w <= n);
        if (all) for (int j = 0; j < w; j++) if (bitv[i+j] != 0) all = 0;
        if (all) begin
          for (int j = 0; j < w; j++) tx_exp[i+j] = 0;
          if (odd != 0) tx_exp[i+w-1] = pc(last);
          else begin
            last = -last; tx_exp[i] = pc(last); tx_exp[i+w-1] = pc(last);
          end
          odd = 0; i += w;
        end else begin
          tx_exp[i] = 0; i++;
        end
      end
    end
    for (int k = 0; k < n; k++) rx_in_code[k] = tx_exp[k];
  endtask

  task automatic build_bypass(int n);
    for (int k = 0; k < n; k++) begin
      tx_in_code[k] = int'(rnd() % 4);
      tx_exp[k] = (tx_in_code[k] == 3) ? 0 : tx_in_code[k];
      rx_in_code[k] = int'(rnd() % 4);
      rx_exp[k] = rx_in_code[k];
    end
  endtask

  task automatic run_stream(int w, bit codec, int n, bit flip_pins, bit los_play,
                            string treq, string rreq);
    int t_in = 0, t_out = 0, r_in = 0, r_out = 0, zr = 0;
    while (t_in < n || r_in < n) begin
      bit tv, rv, tfull, rfull, etv, etr, erv, err;
      @(negedge clk);
      tv = (t_in < n) && ((rnd() % 5) != 0);
      rv = (r_in < n) && ((rnd() % 5) != 0);
      tx_in_valid = tv;
      tx_in_pos = (t_in < n) ? tx_in_code[t_in][1] : 1'b0;
      tx_in_neg = (t_in < n) ? tx_in_code[t_in][0] : 1'b0;
      tx_out_ready = (rnd() % 4) != 0;
      rx_in_valid = rv;
      rx_line_pos = (r_in < n) ? rx_in_code[r_in][1] : 1'b0;
      rx_line_neg = (r_in < n) ? rx_in_code[r_in][0] : 1'b0;
      rx_out_ready = (rnd() % 4) != 0;
      sig_present = los_play ? ((rnd() % 5) != 0) : 1'b1;
      if (flip_pins) begin
        codec_en_n = rnd() % 2;
        hdb3_sel = rnd() % 2;
      end
      #1;
      tfull = (t_in >= w);
      etv = tfull && tv;
      etr = tx_out_ready || !tfull;
      chk(treq, "tx_out_valid", int'(tx_out_valid), int'(etv));
      chk(treq, "tx_in_ready", int'(tx_in_ready), int'(etr));
      if (etv) begin
        int got = int'({tx_line_pos, tx_line_neg});
        chk(treq, "tx symbol", got, tx_exp[t_out]);
        chk("R1", "tx flags exclusive", int'(got == 3), 0);
        if (tx_out_ready) begin
          if (codec) begin
            zr = (got == 0) ? zr + 1 : 0;
            chk("R5", "zero run within limit", int'(zr <= w - 1), 1);
          end
          t_out++;
        end
      end
      if (tv && etr) t_in++;
      rfull = (r_in >= w);
      erv = rfull && rv;
      err = rx_out_ready || !rfull;
      chk(rreq, "rx_out_valid", int'(rx_out_valid), int'(erv));
      chk(rreq, "rx_in_ready", int'(rx_in_ready), int'(err));
      if (!sig_present) chk("R10", "rx blanked", int'({rx_out_pos, rx_out_neg}), 0);
      if (erv) begin
        chk(rreq, "rx symbol", int'({rx_out_pos, rx_out_neg}),
            sig_present ? rx_exp[r_out] : 0);
        if (codec) chk("R7", "rx_out_neg low", int'(rx_out_neg), 0);
        if (rx_out_ready) r_out++;
      end
      if (rv && err) r_in++;
    end
    @(negedge clk);
    tx_in_valid = 0; rx_in_valid = 0; sig_present = 1'b1;
  endtask

  initial begin
    // R3 and R6: three-zero coding and round-trip decode
    do_reset(1'b0, 1'b0);
    build_codec(3, 400);
    run_stream(3, 1'b1, 400, 1'b0, 1'b0, "R3", "R6");
    // R4 with R10: four-zero coding, receive blanking toggled
    do_reset(1'b0, 1'b1);
    build_codec(4, 400);
    run_stream(4, 1'b1, 400, 1'b0, 1'b1, "R4", "R6");
    // R11: mode pins wander after reset, three-zero codec must persist
    do_reset(1'b0, 1'b0);
    build_codec(3, 300);
    run_stream(3, 1'b1, 300, 1'b1, 1'b0, "R11", "R11");
    // R8 and R9: bypass in both window sizes
    do_reset(1'b1, 1'b1);
    build_bypass(300);
    run_stream(4, 1'b0, 300, 1'b0, 1'b0, "R8", "R9");
    do_reset(1'b1, 1'b0);
    build_bypass(300);
    run_stream(3, 1'b0, 300, 1'b0, 1'b0, "R8", "R9");
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule